// File: doc/BRIEF.md
# Microwire EEPROM Word Reader

This block reads one 16-bit word from a three-wire serial EEPROM. The word uses the common Microwire-style protocol, with a select line, a serial clock, a controller-to-device data line and a device-to-controller data line. A host pulses a request with an 8-bit word address. The controller then runs the whole access by itself. It frames the device with chip select and shifts out an 11-bit command: read opcode `110` followed by the address, most significant bit first. It then clocks in sixteen data bits, also most significant bit first. At the end it returns the word with a one-cycle done pulse.

Every pin change is followed by at least one settle phase. The phase length is set by a parameter as a number of system clocks, so slow parts can be served from a fast fabric clock. A presence input reports whether a device is fitted. Without one, a request completes at once with an error flag and the pins stay quiet. Requests that arrive during an access are dropped.

Top module: `mw_eeprom_reader`

## Requirements
- R1: Synchronous active-high reset drives chip select, serial clock and data-out low, and clears busy, done and error; a reset in the middle of an access abandons it.
- R2: A request seen while idle with the device present raises busy on the next clock.
- R3: The outgoing command is 11 bits long. It is sent MSB first and is captured by the device on the serial clock rising edges. Its bits are `1`, `1`, `0`, followed by address bits 7 down to 0.
- R4: Data-out changes at least one phase before each serial clock rising edge, and it holds steady while the clock is high.
- R5: Each serial clock high pulse lasts exactly one phase (PHASE_CLKS system clocks).
- R6: Sixteen data bits are taken MSB first, each sampled one phase after a serial clock falling edge. The device presents each bit after the rising edge of the 12th through 27th clocks. The assembled word appears on the read-data output together with done.
- R7: Chip select rises one phase after acceptance and stays high for exactly 83 phases. The serial clock is never high while chip select is low.
- R8: Data-out is low whenever chip select is low and during the whole read part of the access.
- R9: Done is a single-cycle pulse. For a good read it comes with error low, and busy falls in that same cycle.
- R10: A request during busy is ignored. The running access keeps its address and result, and no extra done pulse or access follows.
- R11: A request with no device present yields done and error on the next clock, with busy low and no chip select activity. The read-data output keeps its previous value.
- R12: Each access produces exactly 27 serial clock rising edges: 11 for the command and 16 for the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Read request pulse |
| req_addr | input | ADDR_W | Word address for the read |
| prom_present | input | 1 | High when a serial EEPROM is fitted |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | With done: request refused, no device |
| rd_data | output | DATA_W | Word read from the device |
| mw_cs | output | 1 | Chip select to the device |
| mw_sk | output | 1 | Serial clock to the device |
| mw_dout | output | 1 | Serial data to the device |
| mw_din | input | 1 | Serial data from the device |

## Verification
The bench reads every one of the 256 addresses through a bus-level model of the device. The model decodes the captured command and answers with an arithmetic word that depends on the address. It exercises the phase timing boundaries. A controller that shifted LSB first, or that dropped or duplicated an opcode bit, would fail on the captured command. One that sampled on the wrong side of the falling edge would return a word shifted by one bit. Mis-sized clock pulses or chip select windows show up as wrong width counts. Three further cases are driven on purpose: a request arriving mid-access, which a faulty design would restart on or answer twice; a request with no device fitted, which a faulty design would turn into pin activity or a lost error; and a reset in the middle of an access, which must leave every pin low.

// File: rtl/mw_pkg.sv
package mw_pkg;
  // read opcode: start bit then two opcode bits
  localparam logic [2:0] RD_OPCODE = 3'b110;
  localparam int OPC_W = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_SEL,
    ST_WSET,
    ST_WHI,
    ST_WLO,
    ST_RGAP,
    ST_RHI,
    ST_RLO,
    ST_FIN
  } mw_state_t;
endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
  parameter int PHASE_CLKS = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mw_piso.sv
module mw_piso #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr;

  assign msb = sr[W-1];

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end
endmodule

// File: rtl/mw_sipo.sv
module mw_sipo #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (shift) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
  import mw_pkg::*;
#(
  parameter int PHASE_CLKS = 250,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              prom_present,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data,
  output logic              mw_cs,
  output logic              mw_sk,
  output logic              mw_dout,
  input  logic              mw_din
);
  localparam int FRAME_W = OPC_W + ADDR_W;
  localparam int MAX_BITS = (FRAME_W > DATA_W) ? FRAME_W : DATA_W;
  localparam int BW = $clog2(MAX_BITS);
  localparam logic [BW-1:0] FRAME_LAST = BW'(FRAME_W - 1);
  localparam logic [BW-1:0] DATA_LAST  = BW'(DATA_W - 1);

  mw_state_t         state;
  logic [BW-1:0]     bcnt;
  logic              tick;
  logic              run;
  logic              accept;
  logic              so_msb;
  logic              so_shift;
  logic              si_shift;
  logic [DATA_W-1:0] si_q;

  assign run      = (state != ST_IDLE);
  assign accept   = (state == ST_IDLE) && req && prom_present;
  assign so_shift = tick && ((state == ST_SEL) ||
                             ((state == ST_WLO) && (bcnt != FRAME_LAST)));
  assign si_shift = tick && (state == ST_RLO);

  mw_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
    .clk (clk),
    .rst (rst),
    .run (run),
    .tick(tick)
  );

  mw_piso #(.W(FRAME_W)) u_cmd (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .load_val({RD_OPCODE, req_addr}),
    .shift   (so_shift),
    .msb     (so_msb)
  );

  mw_sipo #(.W(DATA_W)) u_word (
    .clk  (clk),
    .rst  (rst),
    .clr  (accept),
    .shift(si_shift),
    .din  (mw_din),
    .q    (si_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bcnt    <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      rd_data <= '0;
      mw_cs   <= 1'b0;
      mw_sk   <= 1'b0;
      mw_dout <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req) begin
            if (prom_present) begin
              state <= ST_PRE;
              busy  <= 1'b1;
            end else begin
              done <= 1'b1;
              err  <= 1'b1;
            end
          end
        end
        ST_PRE: if (tick) begin
          mw_cs <= 1'b1;
          state <= ST_SEL;
        end
        ST_SEL: if (tick) begin
          mw_dout <= so_msb;
          bcnt    <= '0;
          state   <= ST_WSET;
        end
        ST_WSET: if (tick) begin
          mw_sk <= 1'b1;
          state <= ST_WHI;
        end
        ST_WHI: if (tick) begin
          mw_sk <= 1'b0;
          state <= ST_WLO;
        end
        ST_WLO: if (tick) begin
          if (bcnt == FRAME_LAST) begin
            mw_dout <= 1'b0;
            bcnt    <= '0;
            state   <= ST_RGAP;
          end else begin
            mw_dout <= so_msb;
            bcnt    <= bcnt + 1'b1;
            state   <= ST_WSET;
          end
        end
        ST_RGAP: if (tick) begin
          mw_sk <= 1'b1;
          state <= ST_RHI;
        end
        ST_RHI: if (tick) begin
          mw_sk <= 1'b0;
          state <= ST_RLO;
        end
        ST_RLO: if (tick) begin
          if (bcnt == DATA_LAST) begin
            state <= ST_FIN;
          end else begin
            bcnt  <= bcnt + 1'b1;
            state <= ST_RGAP;
          end
        end
        ST_FIN: if (tick) begin
          mw_cs   <= 1'b0;
          busy    <= 1'b0;
          done    <= 1'b1;
          rd_data <= si_q;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk (
  input logic clk,
  input logic rst,
  input logic req,
  input logic prom_present,
  input logic busy,
  input logic done,
  input logic err,
  input logic mw_cs,
  input logic mw_sk,
  input logic mw_dout
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!mw_cs && !mw_sk && !mw_dout && !busy && !done && !err));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !busy && prom_present) |=> busy);

  // R4
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mw_sk && $past(mw_sk)) |-> $stable(mw_dout));

  // R7
  clk_inside_cs_chk: assert property (@(posedge clk) disable iff (rst)
    mw_sk |-> mw_cs);

  // R8
  dout_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !mw_cs |-> !mw_dout);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done && !err));

  // R11
  refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !busy && !prom_present) |=> (done && err && !busy && !mw_cs));

  // R11
  err_alone_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && !busy));
endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req         (req),
  .prom_present(prom_present),
  .busy        (busy),
  .done        (done),
  .err         (err),
  .mw_cs       (mw_cs),
  .mw_sk       (mw_sk),
  .mw_dout     (mw_dout)
);

// File: tb/tb_mw_eeprom_reader.sv
`timescale 1ns/1ps
module tb_mw_eeprom_reader;
  localparam int P  = 2;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          present = 1'b1;
  logic          din = 1'b0;
  logic          busy, done, err, cs, sk, dout;
  logic [DW-1:0] rd_data;

  always #2 clk = ~clk;

  mw_eeprom_reader #(.PHASE_CLKS(P), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .req(req), .req_addr(addr), .prom_present(present),
    .busy(busy), .done(done), .err(err), .rd_data(rd_data),
    .mw_cs(cs), .mw_sk(sk), .mw_dout(dout), .mw_din(din)
  );

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit finished = 0;

  function automatic logic [15:0] word_of(input logic [7:0] a);
    return {a ^ 8'h3C, ~a + 8'd7};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_up();
    end
  end

  // device model and pin-timing monitor
  logic [7:0]  exp_addr = '0;
  logic [10:0] cmd = '0;
  logic [15:0] w;
  logic        sk_prev = 0, cs_prev = 0, dout_prev = 0;
  int ridx = 0, dage = 1000, sk_hi = 0, cs_hi = 0, frames = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (dout !== dout_prev) dage = 0; else dage++;
      if (cs && !cs_prev) begin ridx = 0; cmd = '0; cs_hi = 0; end
      if (cs) cs_hi++;
      if (sk) sk_hi++;
      if (sk && !sk_prev) begin
        ridx++;
        check(dage >= P, "R4 data-out setup before rise", 32'(dage), 32'(P));
        if (ridx <= 11) cmd = {cmd[9:0], dout};
        else begin
          check(dout == 1'b0, "R8 data-out low during read", 32'(dout), 0);
          if (ridx <= 27) begin
            w = word_of(cmd[7:0]);
            din = w[15-(ridx-12)];
          end
        end
      end
      if (sk && sk_prev)
        check(dout == dout_prev, "R4 data-out stable while clock high", 32'(dout), 32'(dout_prev));
      if (!sk && sk_prev) begin
        check(sk_hi == P, "R5 clock high width", 32'(sk_hi), 32'(P));
        sk_hi = 0;
      end
      if (!cs && cs_prev) begin
        frames++;
        check(ridx == 27, "R12 clock rises per access", 32'(ridx), 27);
        check(cmd == {3'b110, exp_addr}, "R3 command frame", 32'(cmd), 32'({3'b110, exp_addr}));
        check(cs_hi == 83*P, "R7 select window", 32'(cs_hi), 32'(83*P));
        din = 1'b0;
      end
    end else begin
      sk_hi = 0;
      din = 1'b0;
    end
    sk_prev   = sk;
    cs_prev   = cs;
    dout_prev = dout;
  end

  task automatic pulse_req(input logic [7:0] a);
    @(negedge clk);
    addr = a;
    req  = 1'b1;
    @(negedge clk);
    req  = 1'b0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 2000 && !done; n++) @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] a);
    exp_addr = a;
    pulse_req(a);
    check(busy, "R2 busy after request", 32'(busy), 1);
    wait_done();
    check(done && !err, "R9 done without error", 32'({done, err}), 32'b10);
    check(!busy, "R9 busy low with done", 32'(busy), 0);
    check(rd_data == word_of(a), "R6 read word", 32'(rd_data), 32'(word_of(a)));
    @(negedge clk);
    check(!done, "R9 done lasts one cycle", 32'(done), 0);
  endtask

  initial begin
    int f0;
    int extra;
    logic [15:0] held;
    repeat (4) @(negedge clk);
    check(!cs && !sk && !dout && !busy && !done && !err, "R1 reset state",
          32'({cs, sk, dout, busy, done, err}), 0);
    rst = 1'b0;
    @(negedge clk);

    // full address sweep
    for (int a = 0; a < 256; a++) do_read(8'(a));

    // R10: second request during an access
    exp_addr = 8'h21;
    pulse_req(8'h21);
    f0 = frames;
    repeat (40) @(negedge clk);
    pulse_req(8'hDE);
    wait_done();
    check(rd_data == word_of(8'h21), "R10 running access keeps its address",
          32'(rd_data), 32'(word_of(8'h21)));
    @(negedge clk);
    extra = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done || cs) extra++;
    end
    check(extra == 0, "R10 no second access", 32'(extra), 0);
    check(frames == f0 + 1, "R10 one frame only", 32'(frames), 32'(f0 + 1));

    // R11: no device present
    present = 1'b0;
    held = rd_data;
    f0 = frames;
    pulse_req(8'h07);
    check(done && err && !busy, "R11 refused at once", 32'({done, err, busy}), 32'b110);
    check(rd_data == held, "R11 read data kept", 32'(rd_data), 32'(held));
    extra = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (cs || sk || dout || busy) extra++;
    end
    check(extra == 0, "R11 no pin activity", 32'(extra), 0);
    check(frames == f0, "R11 no frame", 32'(frames), 32'(f0));
    present = 1'b1;

    // R1: reset in the middle of an access
    exp_addr = 8'h44;
    pulse_req(8'h44);
    repeat (60) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!cs && !sk && !dout && !busy, "R1 reset aborts access",
          32'({cs, sk, dout, busy}), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    do_read(8'h55);

    finish_up();
  end
endmodule